// File: doc/BRIEF.md
# Multi-Mode Barrel Shifter

This block is a purely combinational shifter for a word of parameterised width (16 bits unless overridden). In the same cycle it shifts or rotates an operand by a variable count, in a direction and a mode chosen at its inputs. It is meant to sit in an execution datapath next to the adder. The result and a carry flag are ready within the same cycle, and whatever flag storage the datapath has takes them from there.

Three modes are offered: logical, arithmetic and rotate. The arithmetic left shift holds the sign bit in place and moves only the bits beneath it. The carry output reports the last bit that left the word, or the field in the arithmetic-left case. A rotate has no end to leave, so its carry reports the last bit that wrapped around.

Top module: `barrel_shifter_mm`

## Requirements
- R1: When the shift amount is 0, result equals the operand and carry is 0, whatever the mode and direction.
- R2: Mode code 0 (and the spare code 3) is logical. Direction 0 shifts left and direction 1 shifts right. Vacated positions are filled with zeros.
- R3: For logical shifts and the arithmetic right shift, amounts of W or more act as exactly W. Logical then gives all zeros. Arithmetic right gives every bit equal to the operand's bit W-1.
- R4: Mode code 1 with direction 1 is an arithmetic right shift. Vacated high positions receive copies of operand bit W-1.
- R5: Mode code 1 with direction 0 keeps result bit W-1 equal to operand bit W-1. Bits W-2..0 shift left with zero fill. Amounts of W-1 or more clear all of bits W-2..0.
- R6: Mode code 2 rotates in either direction. Bits leaving one end re-enter at the other, and the amount is taken modulo W.
- R7: For logical shifts and the arithmetic right shift with effective count k (1..W), carry is operand bit W-k when shifting left and operand bit k-1 when shifting right.
- R8: For the arithmetic left shift with effective count k = min(amount, W-1), carry is operand bit W-1-k. This is the last bit pushed out of bit position W-2.
- R9: For a non-zero rotate amount, carry is the last bit that wrapped around. That is result bit 0 for a left rotate and result bit W-1 for a right rotate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | W | Word to be shifted |
| amount_i | input | $clog2(W)+1 | Shift or rotate count |
| dir_i | input | 1 | 0 = left, 1 = right |
| mode_i | input | 2 | 0 logical, 1 arithmetic, 2 rotate, 3 logical |
| result_o | output | W | Shifted word |
| carry_o | output | 1 | Last bit shifted out or wrapped |

## Verification
The block has no state, so the assertions only relate this cycle's inputs to this cycle's outputs. They assume the inputs are stable, two-valued levels at the moment they are evaluated. The bench therefore changes inputs only on the falling clock edge and compares on the rising edge, after the logic has settled. The count range is full: amounts run up to the largest value the port can carry, well past W, so the saturation and modulo paths are reached along with the ordinary ones.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

  typedef enum logic {
    SH_LEFT  = 1'b0,
    SH_RIGHT = 1'b1
  } sh_dir_e;

  typedef enum logic [1:0] {
    SH_LOGIC  = 2'd0,
    SH_ARITH  = 2'd1,
    SH_ROTATE = 2'd2,
    SH_SPARE  = 2'd3
  } sh_mode_e;

endpackage

// File: rtl/bshift_amt_norm.sv
// Turns the raw count into the count the stages apply: modulo W for
// rotates, clamped to the field width for shifts.
module bshift_amt_norm #(
  parameter int W  = 16,
  parameter int AW = $clog2(W) + 1
) (
  input  logic [AW-1:0] amt,
  input  logic          rot,
  input  logic          ari_left,
  output logic [AW-1:0] eff,
  output logic          is_zero
);

  localparam logic [AW-1:0] LIM_WORD  = AW'(W);
  localparam logic [AW-1:0] LIM_FIELD = AW'(W - 1);

  always_comb begin
    is_zero = (amt == '0);
    if (rot) begin
      eff = AW'(int'(amt) % W);
    end else if (ari_left) begin
      eff = (amt > LIM_FIELD) ? LIM_FIELD : amt;
    end else begin
      eff = (amt > LIM_WORD) ? LIM_WORD : amt;
    end
  end

endmodule

// File: rtl/bshift_core.sv
// Logarithmic shifter: one stage per count bit. It always shifts right;
// a left shift is built by mirroring the word on the way in and out.
module bshift_core #(
  parameter int N  = 16,
  parameter int CW = $clog2(N) + 1
) (
  input  logic [N-1:0]  din,
  input  logic [CW-1:0] amt,
  input  logic          to_left,
  input  logic          rot,
  input  logic          fill,
  output logic [N-1:0]  dout
);

  function automatic logic [N-1:0] rot_r(input logic [N-1:0] v, input int s);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = v[(i + s) % N];
    return r;
  endfunction

  function automatic logic [N-1:0] shf_r(input logic [N-1:0] v, input int s,
                                         input logic f);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      if (i + s < N) r[i] = v[i + s];
      else           r[i] = f;
    end
    return r;
  endfunction

  logic [N-1:0] pre;
  logic [N-1:0] st [CW+1];

  for (genvar i = 0; i < N; i++) begin : g_mirror_in
    assign pre[i] = to_left ? din[N-1-i] : din[i];
  end

  assign st[0] = pre;

  for (genvar g = 0; g < CW; g++) begin : g_stage
    localparam int SH = 1 << g;
    assign st[g+1] = amt[g] ? (rot ? rot_r(st[g], SH % N) : shf_r(st[g], SH, fill))
                            : st[g];
  end

  for (genvar i = 0; i < N; i++) begin : g_mirror_out
    assign dout[i] = to_left ? st[CW][N-1-i] : st[CW][i];
  end

endmodule

// File: rtl/bshift_carry.sv
// Chooses the carry bit from the effective count and the mode.
module bshift_carry #(
  parameter int W  = 16,
  parameter int AW = $clog2(W) + 1
) (
  input  logic [W-1:0]  din,
  input  logic [W-1:0]  res,
  input  logic [AW-1:0] eff,
  input  logic          is_zero,
  input  logic          left,
  input  logic          rot,
  input  logic          ari,
  output logic          cout
);

  int idx;

  always_comb begin
    idx  = 0;
    cout = 1'b0;
    if (!is_zero) begin
      if (rot) begin
        // the bit that wrapped last lands at the entry end
        cout = left ? res[0] : res[W-1];
      end else begin
        if (!left)    idx = int'(eff) - 1;
        else if (ari) idx = W - 1 - int'(eff);
        else          idx = W - int'(eff);
        if (idx >= 0 && idx < W) cout = din[idx];
      end
    end
  end

endmodule

// File: rtl/barrel_shifter_mm.sv
module barrel_shifter_mm #(
  parameter int W  = 16,
  parameter int AW = $clog2(W) + 1
) (
  input  logic [W-1:0]  operand_i,
  input  logic [AW-1:0] amount_i,
  input  logic          dir_i,
  input  logic [1:0]    mode_i,
  output logic [W-1:0]  result_o,
  output logic          carry_o
);
  import bshift_pkg::*;

  sh_mode_e      mode;
  sh_dir_e       dir;
  logic          rot, ari, left, ari_left;
  logic [AW-1:0] eff;
  logic          is_zero;
  logic [W-1:0]  main_out;
  logic [W-2:0]  field_out;
  logic          fill;

  assign mode     = sh_mode_e'(mode_i);
  assign dir      = sh_dir_e'(dir_i);
  assign rot      = (mode == SH_ROTATE);
  assign ari      = (mode == SH_ARITH);
  assign left     = (dir == SH_LEFT);
  assign ari_left = ari & left;
  assign fill     = ari & ~left & operand_i[W-1];

  bshift_amt_norm #(.W(W), .AW(AW)) u_norm (
    .amt      (amount_i),
    .rot      (rot),
    .ari_left (ari_left),
    .eff      (eff),
    .is_zero  (is_zero)
  );

  bshift_core #(.N(W), .CW(AW)) u_word (
    .din     (operand_i),
    .amt     (eff),
    .to_left (left),
    .rot     (rot),
    .fill    (fill),
    .dout    (main_out)
  );

  // Field below the sign bit, used only by the arithmetic left shift
  bshift_core #(.N(W-1), .CW(AW)) u_field (
    .din     (operand_i[W-2:0]),
    .amt     (eff),
    .to_left (1'b1),
    .rot     (1'b0),
    .fill    (1'b0),
    .dout    (field_out)
  );

  assign result_o = ari_left ? {operand_i[W-1], field_out} : main_out;

  bshift_carry #(.W(W), .AW(AW)) u_carry (
    .din     (operand_i),
    .res     (result_o),
    .eff     (eff),
    .is_zero (is_zero),
    .left    (left),
    .rot     (rot),
    .ari     (ari),
    .cout    (carry_o)
  );

  always_comb begin
    if (amount_i == '0) begin
      a_r1_zero_pass: assert (result_o == operand_i && carry_o == 1'b0);
    end
    if (ari_left) begin
      a_r5_sign_held: assert (result_o[W-1] == operand_i[W-1]);
    end
    if (ari && !left) begin
      a_r4_sign_copied: assert (result_o[W-1] == operand_i[W-1]);
    end
    if (!rot && !ari && amount_i >= AW'(W)) begin
      a_r3_logic_saturate: assert (result_o == '0);
    end
    if (rot) begin
      a_r6_rotate_keeps_bits: assert ($countones(result_o) == $countones(operand_i));
    end
  end

endmodule

// File: tb/barrel_shifter_mm_tb.sv
module barrel_shifter_mm_tb;
  localparam int W  = 16;
  localparam int AW = $clog2(W) + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  operand_i = '0;
  logic [AW-1:0] amount_i = '0;
  logic          dir_i = 1'b0;
  logic [1:0]    mode_i = 2'd0;
  logic [W-1:0]  result_o;
  logic          carry_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [W:0] exp_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  barrel_shifter_mm #(.W(W), .AW(AW)) u_dut (
    .operand_i (operand_i),
    .amount_i  (amount_i),
    .dir_i     (dir_i),
    .mode_i    (mode_i),
    .result_o  (result_o),
    .carry_o   (carry_o)
  );

  // Bit-at-a-time model written from the requirements
  function automatic logic [W:0] ref_model(logic [W-1:0] a, int n, logic d,
                                           logic [1:0] m);
    logic [W-1:0] v;
    logic c;
    int steps;
    v = a;
    c = 1'b0;
    if (n == 0) return {1'b0, a};
    if (m == 2'd2)                    steps = n;
    else if (m == 2'd1 && d == 1'b0)  steps = (n > W-1) ? W-1 : n;
    else                              steps = (n > W) ? W : n;
    for (int s = 0; s < steps; s++) begin
      if (m == 2'd2) begin
        if (!d) begin c = v[W-1]; v = {v[W-2:0], v[W-1]}; end
        else    begin c = v[0];   v = {v[0], v[W-1:1]};   end
      end else if (m == 2'd1) begin
        if (!d) begin c = v[W-2]; v = {v[W-1], v[W-3:0], 1'b0}; end
        else    begin c = v[0];   v = {v[W-1], v[W-1:1]};       end
      end else begin
        if (!d) begin c = v[W-1]; v = {v[W-2:0], 1'b0}; end
        else    begin c = v[0];   v = {1'b0, v[W-1:1]}; end
      end
    end
    return {c, v};
  endfunction

  task automatic drive(logic [W-1:0] a, int n, logic d, logic [1:0] m, string tag);
    @(negedge clk);
    operand_i = a;
    amount_i  = AW'(n);
    dir_i     = d;
    mode_i    = m;
    exp_q.push_back(ref_model(a, n, d, m));
    tag_q.push_back(tag);
  endtask

  // Monitor: the logic has settled by the rising edge after the drive
  always @(posedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      logic [W:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if ({carry_o, result_o} !== e) begin
        bad++;
        $display("FAIL %s: got carry=%0b result=%h expected carry=%0b result=%h",
                 t, carry_o, result_o, e[W], e[W-1:0]);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got running expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] lfsr;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1: zero count in every mode and direction
    for (int m = 0; m < 4; m++) begin
      drive(16'hB3C5, 0, 1'b0, 2'(m), "R1 zero count left");
      drive(16'h8001, 0, 1'b1, 2'(m), "R1 zero count right");
    end
    // R2, R7: logical left and right
    drive(16'h1234, 4, 1'b0, 2'd0, "R2 logical left");
    drive(16'h1234, 4, 1'b1, 2'd0, "R2 logical right");
    drive(16'h8001, 1, 1'b0, 2'd0, "R7 carry left msb out");
    drive(16'h8001, 1, 1'b1, 2'd0, "R7 carry right lsb out");
    drive(16'hF00F, 5, 1'b0, 2'd3, "R2 spare code is logical");
    // R3: saturation
    drive(16'h0001, 16, 1'b0, 2'd0, "R3 logical left by W");
    drive(16'h8000, 31, 1'b1, 2'd0, "R3 logical right past W");
    drive(16'h9000, 20, 1'b1, 2'd1, "R3 arith right past W");
    drive(16'h7FFF, 16, 1'b1, 2'd1, "R3 arith right by W positive");
    // R4: arithmetic right
    drive(16'h8F00, 4, 1'b1, 2'd1, "R4 arith right negative");
    drive(16'h4F00, 3, 1'b1, 2'd1, "R4 arith right positive");
    // R5, R8: arithmetic left
    drive(16'h8003, 2, 1'b0, 2'd1, "R5 arith left sign kept");
    drive(16'h4001, 1, 1'b0, 2'd1, "R8 carry from bit below sign");
    drive(16'hFFFF, 15, 1'b0, 2'd1, "R5 arith left by W-1");
    drive(16'h7FFE, 30, 1'b0, 2'd1, "R8 arith left saturated carry");
    // R6, R9: rotates
    drive(16'h8001, 1, 1'b0, 2'd2, "R6 rotate left wrap");
    drive(16'h8001, 1, 1'b1, 2'd2, "R6 rotate right wrap");
    drive(16'h1234, 16, 1'b0, 2'd2, "R9 rotate left by W");
    drive(16'h1234, 20, 1'b1, 2'd2, "R6 rotate right modulo");
    drive(16'h0001, 17, 1'b1, 2'd2, "R9 rotate right carry");
    // sweep
    lfsr = 16'hACE1;
    for (int i = 0; i < 800; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (i % 3)
        0: drive(lfsr, i % 32, lfsr[3], 2'd0, "R7 sweep logical");
        1: drive(lfsr, i % 32, lfsr[5], 2'd1, "R8 sweep arithmetic");
        default: drive(lfsr, i % 32, lfsr[7], 2'd2, "R9 sweep rotate");
      endcase
    end
    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule